// File: doc/BRIEF.md
# Current-Sense ADC Register Interface

This block is the slave side of a current-sense ADC peripheral. A host reaches it over a byte-wide register bus: an address, write data, a write strobe, a read strobe and combinational read data. Behind the bus sit fixed identification bytes, a set of configuration bytes, a power enable, a conversion-request trigger, a status byte, a 16-bit result and a guarded reset-control byte.

A conversion is started by setting the trigger bit while the peripheral is powered. A timer then runs for a fixed number of cycles. When it expires, the block captures a behavioural sample input as the result, sets end-of-conversion and pulses an interrupt for one cycle. The reset-control byte can only be changed by a write that comes straight after a key write. Any other bus access in between cancels the key.

The sample is a level that is taken when the timer expires, so there is no back-pressure at any edge. The bus is always ready, a read is answered in the cycle it is presented, and the interrupt and the warm-reset selection are plain pins.

Top module: `cadc_regif`

## Requirements
- R1: The identification bytes read as fixed values: address 0x01 reads 0x01, 0x04 reads 0x08 and 0x05 reads 0x03.
- R2: The configuration bytes at 0x40, 0x48, 0x50, 0x51 and 0x5A keep all 8 written bits. The enable byte at 0x46 and the averaging-enable byte at 0x5B keep only bit 7 and read 0 in bits 6..0.
- R3: Writing a byte with bit 7 set to 0x52 while bit 7 of 0x46 is set starts a conversion. Status byte 0x08 then reads 0x02 (bit 1 = pending, bit 0 = end-of-conversion). Exactly CONV_CYCLES clock edges after the request edge, the status reads 0x01 and the result holds the sample.
- R4: A request while bit 7 of 0x46 is clear is ignored: the status stays 0x00 and no interrupt is raised.
- R5: eoc_irq is high for exactly one cycle per completed conversion.
- R6: The result is little-endian. The low byte is at 0x60 and the high byte at 0x61. A read of 0x60 latches the high byte into 0x61, and 0x61 does not change until 0x60 is read again.
- R7: A write to 0xDA is accepted only when the previous bus access was a write of 0xA5 to 0xD0. 0xDA reads back its stored byte, and warm_follow reflects its bit 2.
- R8: The key is consumed by one access. Any read, any other write, or a key write of a value other than 0xA5 leaves the next write to 0xDA without effect.
- R9: Writing 0x46 with bit 7 clear aborts a running conversion: the status reads 0x00 and no interrupt follows.
- R10: A new request clears end-of-conversion. The status reads 0x02 until the new conversion completes.
- R11: Address 0xF4 reads the TRIM_VALUE parameter (bit 7 = sign), and writes to it have no effect.
- R12: After reset, every writable byte and the status read 0x00. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe, one access per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| adc_sample | input | 16 | Behavioural converter output, captured at completion |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |
| warm_follow | output | 1 | Bit 2 of the reset-control byte |

## Verification
The bench measures the conversion length edge by edge, so a timer that is off by one shows up as a wrong count. It checks that a second conversion leaves the high result byte stale until the low byte is read again; a design that reads the high byte live would return the new value. On the key guard it puts a read, a wrong key and a second protected write after the key, and a guard that only remembers a key write would accept writes it should reject. It also aborts a running conversion and requests while unpowered; a design that keeps the timer running would raise a stray interrupt or a set status bit.

// File: rtl/cadc_pkg.sv
package cadc_pkg;
  localparam logic [7:0] A_REV    = 8'h01;
  localparam logic [7:0] A_TYPE   = 8'h04;
  localparam logic [7:0] A_SUBT   = 8'h05;
  localparam logic [7:0] A_STAT   = 8'h08;
  localparam logic [7:0] A_REQ    = 8'h52;
  localparam logic [7:0] A_RES_LO = 8'h60;
  localparam logic [7:0] A_RES_HI = 8'h61;
  localparam logic [7:0] A_KEY    = 8'hD0;
  localparam logic [7:0] A_RSTCTL = 8'hDA;
  localparam logic [7:0] A_TRIM   = 8'hF4;

  localparam logic [7:0] V_REV  = 8'h01;
  localparam logic [7:0] V_TYPE = 8'h08;
  localparam logic [7:0] V_SUBT = 8'h03;
  localparam logic [7:0] KEY_VAL = 8'hA5;

  localparam int RES_W = 16;

  // plain configuration bytes: address and writable-bit mask
  localparam int NUM_CFG = 7;
  localparam int CFG_EN_IDX = 1;
  localparam logic [7:0] CFG_ADDR [NUM_CFG] =
    '{8'h40, 8'h46, 8'h48, 8'h50, 8'h51, 8'h5A, 8'h5B};
  localparam logic [7:0] CFG_MASK [NUM_CFG] =
    '{8'hFF, 8'h80, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h80};
endpackage

// File: rtl/cadc_unlock.sv
module cadc_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic key_hit,
  output logic unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       unlocked <= 1'b0;
    else if (key_hit) unlocked <= 1'b1;
    else if (access)  unlocked <= 1'b0;
  end

  // R7: the guard only opens after a key write
  assert_unlock_from_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_hit));
endmodule

// File: rtl/cadc_conv.sv
module cadc_conv #(
  parameter int CONV_CYCLES = 16,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [RES_W-1:0] sample,
  output logic             busy,
  output logic             eoc,
  output logic             irq,
  output logic [RES_W-1:0] result
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             done;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      eoc    <= 1'b0;
      irq    <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else begin
      irq <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        eoc  <= 1'b0;
      end else if (start) begin
        busy <= 1'b1;
        eoc  <= 1'b0;
        cnt  <= '0;
      end else if (done) begin
        busy   <= 1'b0;
        eoc    <= 1'b1;
        irq    <= 1'b1;
        result <= sample;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_irq_with_eoc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (eoc && !busy));
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !eoc && !irq));
  assert_result_only_on_eoc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(result));
endmodule

// File: rtl/cadc_regif.sv
module cadc_regif
  import cadc_pkg::*;
#(
  parameter int         CONV_CYCLES = 16,
  parameter logic [7:0] TRIM_VALUE  = 8'h8B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_we,
  input  logic        bus_re,
  output logic [7:0]  bus_rdata,
  input  logic [15:0] adc_sample,
  output logic        eoc_irq,
  output logic        warm_follow
);
  logic [7:0]       cfg_q [NUM_CFG];
  logic [7:0]       rstctl_q;
  logic [7:0]       hi_shadow_q;
  logic             unlocked;
  logic             conv_busy, conv_eoc, conv_start, conv_abort;
  logic [RES_W-1:0] conv_result;
  logic             en_on;

  assign en_on = cfg_q[CFG_EN_IDX][7];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_q[gi] <= '0;
        else if (bus_we && bus_addr == CFG_ADDR[gi])
          cfg_q[gi] <= bus_wdata & CFG_MASK[gi];
      end
    end
  endgenerate

  assign conv_start = bus_we && bus_addr == A_REQ && bus_wdata[7] && en_on;
  assign conv_abort = bus_we && bus_addr == CFG_ADDR[CFG_EN_IDX] && !bus_wdata[7];

  cadc_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .access   (bus_we || bus_re),
    .key_hit  (bus_we && bus_addr == A_KEY && bus_wdata == KEY_VAL),
    .unlocked (unlocked)
  );

  cadc_conv #(.CONV_CYCLES(CONV_CYCLES), .RES_W(RES_W)) u_conv (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (conv_start),
    .abort  (conv_abort),
    .sample (adc_sample),
    .busy   (conv_busy),
    .eoc    (conv_eoc),
    .irq    (eoc_irq),
    .result (conv_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstctl_q    <= '0;
      hi_shadow_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_RSTCTL && unlocked)
        rstctl_q <= bus_wdata;
      if (bus_re && bus_addr == A_RES_LO)
        hi_shadow_q <= conv_result[15:8];
    end
  end

  assign warm_follow = rstctl_q[2];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:    bus_rdata = V_REV;
      A_TYPE:   bus_rdata = V_TYPE;
      A_SUBT:   bus_rdata = V_SUBT;
      A_STAT:   bus_rdata = {6'b0, conv_busy, conv_eoc};
      A_REQ:    bus_rdata = {conv_busy, 7'b0};
      A_RES_LO: bus_rdata = conv_result[7:0];
      A_RES_HI: bus_rdata = hi_shadow_q;
      A_RSTCTL: bus_rdata = rstctl_q;
      A_TRIM:   bus_rdata = TRIM_VALUE;
      default: begin
        for (int i = 0; i < NUM_CFG; i++)
          if (bus_addr == CFG_ADDR[i]) bus_rdata = cfg_q[i];
      end
    endcase
  end

  assert_req_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_REQ && !en_on) |=> !conv_busy);
  assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_RSTCTL && !unlocked) |=> $stable(rstctl_q));
endmodule

// File: tb/cadc_regif_tb.sv
module cadc_regif_tb;
  localparam int N = 16;
  localparam logic [7:0] TRIM = 8'h8B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] adc_sample = 16'hBEEF;
  logic eoc_irq, warm_follow;

  int checks = 0, errors = 0, irq_cnt = 0;

  always #10 clk = ~clk;

  cadc_regif #(.CONV_CYCLES(N), .TRIM_VALUE(TRIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .adc_sample(adc_sample), .eoc_irq(eoc_irq), .warm_follow(warm_follow)
  );

  always @(negedge clk) if (rst_n && eoc_irq) irq_cnt++;

  // {we, addr, wdata, expected readback}
  localparam int NV = 12;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h01, 8'h00, 8'h01},
    {1'b0, 8'h04, 8'h00, 8'h08},
    {1'b0, 8'h05, 8'h00, 8'h03},
    {1'b1, 8'h40, 8'h19, 8'h19},
    {1'b1, 8'h48, 8'h05, 8'h05},
    {1'b1, 8'h50, 8'h0C, 8'h0C},
    {1'b1, 8'h51, 8'h7F, 8'h7F},
    {1'b1, 8'h5A, 8'h03, 8'h03},
    {1'b1, 8'h5B, 8'hFF, 8'h80},
    {1'b1, 8'h77, 8'hAA, 8'h00},
    {1'b1, 8'h46, 8'h7F, 8'h00},
    {1'b1, 8'h46, 8'h80, 8'h80}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int k, base;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R12 reset state
    rd(8'h08, v); chk("R12 status after reset", v, 8'h00);
    rd(8'hDA, v); chk("R12 rstctl after reset", v, 8'h00);
    rd(8'h46, v); chk("R12 enable after reset", v, 8'h00);
    chk("R12 irq after reset", eoc_irq, 1'b0);

    // R4 request while unpowered
    wr(8'h52, 8'h80);
    idle(N + 4);
    rd(8'h08, v); chk("R4 status unpowered request", v, 8'h00);
    chk("R4 no irq unpowered", irq_cnt, 0);

    // table: R1, R2, R12
    for (int i = 0; i < NV; i++) begin
      string tag;
      if (VEC[i][23:16] inside {8'h01, 8'h04, 8'h05}) tag = "R1 id";
      else if (VEC[i][23:16] == 8'h77)                 tag = "R12 unmapped";
      else                                             tag = "R2 config";
      if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], v);
      chk(tag, v, VEC[i][7:0]);
    end

    // R3 / R5 timing of a conversion
    base = irq_cnt;
    wr(8'h52, 8'h80);
    k = 0;
    for (int i = 1; i <= N + 4; i++) begin
      @(negedge clk);
      if (eoc_irq) begin k = i; break; end
    end
    chk("R3 conversion length", k, N);
    @(negedge clk);
    chk("R5 irq one cycle", eoc_irq, 1'b0);
    chk("R5 irq count", irq_cnt - base, 1);
    rd(8'h08, v); chk("R3 status done", v, 8'h01);

    // R6 little-endian and high-byte latch
    rd(8'h60, v); chk("R6 low byte", v, 8'hEF);
    rd(8'h61, v); chk("R6 high byte", v, 8'hBE);

    // R10 new request clears eoc
    adc_sample = 16'h1234;
    wr(8'h52, 8'h80);
    rd(8'h08, v); chk("R10 status pending", v, 8'h02);
    rd(8'h52, v); chk("R3 request pending bit", v, 8'h80);
    idle(N + 2);
    rd(8'h08, v); chk("R3 status second done", v, 8'h01);
    rd(8'h61, v); chk("R6 high byte stale", v, 8'hBE);
    rd(8'h60, v); chk("R6 new low byte", v, 8'h34);
    rd(8'h61, v); chk("R6 new high byte", v, 8'h12);

    // R9 abort
    base = irq_cnt;
    wr(8'h52, 8'h80);
    idle(3);
    wr(8'h46, 8'h00);
    rd(8'h08, v); chk("R9 status after abort", v, 8'h00);
    idle(N + 4);
    chk("R9 no irq after abort", irq_cnt - base, 0);
    rd(8'h08, v); chk("R9 status stays idle", v, 8'h00);

    // R7 protected write
    wr(8'hD0, 8'hA5);
    wr(8'hDA, 8'h04);
    rd(8'hDA, v); chk("R7 rstctl accepted", v, 8'h04);
    chk("R7 warm_follow", warm_follow, 1'b1);

    // R8 guard cases
    wr(8'hDA, 8'h00);
    rd(8'hDA, v); chk("R8 no key", v, 8'h04);
    wr(8'hD0, 8'hA5);
    rd(8'h01, v);
    wr(8'hDA, 8'h00);
    rd(8'hDA, v); chk("R8 read cancels key", v, 8'h04);
    wr(8'hD0, 8'hA5);
    wr(8'hDA, 8'h06);
    wr(8'hDA, 8'h00);
    rd(8'hDA, v); chk("R8 key consumed once", v, 8'h06);
    wr(8'hD0, 8'h5A);
    wr(8'hDA, 8'h00);
    rd(8'hDA, v); chk("R8 wrong key", v, 8'h06);
    chk("R7 warm_follow kept", warm_follow, 1'b1);

    // R11 trim byte
    rd(8'hF4, v); chk("R11 trim value", v, TRIM);
    wr(8'hF4, 8'h00);
    rd(8'hF4, v); chk("R11 trim read-only", v, TRIM);

    finish_run();
  end
endmodule